// File: doc/BRIEF.md
# Power-Fail Time-Save Controller

This block sits between the analog supply monitors and the host side of a timekeeping unit. It takes three digital flags: main supply failing, battery above main, and battery low. When main power fails, it filters the failing flag over a debounce window that the host programs. Once the flag has been acted on, the block locks out host writes and raises a sticky interrupt. It moves the supply select to the battery as soon as the battery rises above the main rail. On that rising edge it copies the live time bus into a holding register, if time-save is enabled.

When main power comes back, the same debounce window must pass before anything is released. The lockout then lifts, the supply select returns to main, and a system-power status bit records the recovery. A sticky status word reports four conditions: the interrupt, a cold start with battery only, system power restored, and low battery. The host clears each of these bits by writing 1 to it. A small control register sets the debounce length and the time-save enable.

Top module: `pwr_fail_ctrl`

## Requirements
- R1: After reset, irq_o, lockout_o, bat_sel_o, status_o and ts_en_o read 0, and deb_len_o reads the parameter DEB_RST (4 by default).
- R2: main_fail_i changes the filtered power state only after it has differed from that state on N consecutive rising clock edges. N is deb_len_o, and a length of 0 acts as 1. A shorter pulse has no effect at the ports.
- R3: lockout_o is 1 from the edge at which a failure is accepted until recovery is accepted. While lockout_o is 1, every host write (control or status clear) is ignored.
- R4: status bit 0 (the interrupt, also driven on irq_o) is set on the edge at which a failure is accepted. It stays set until the host writes a 1 in wdata bit 0 with host_sel=0 while not locked out.
- R5: Recovery is accepted after main_fail_i has been low for N consecutive edges. On that edge lockout_o falls and status bit 2 (system power restored) is set.
- R6: bat_sel_o is 1 on the edge after bat_above_i is seen high. It stays 1 while the filtered failure persists, and returns to 0 once bat_above_i is low and no failure is held.
- R7: On a rising edge of bat_above_i with ts_en_o=1, saved_time_o takes time_i from that edge. Only one capture is made per failure event; the capture is re-armed when recovery is accepted.
- R8: With ts_en_o=0, a rising edge of bat_above_i leaves saved_time_o unchanged.
- R9: Status bit 1 (cold battery start) takes the value of cold_boot on the first edge after reset release. It then stays set until it is cleared by a write of 1.
- R10: Status bit 3 (low battery) is set on any edge at which bat_low_i is 1, and stays set until it is cleared by a write of 1.
- R11: A host write with host_sel=1 loads deb_len from wdata[15:8] and ts_en from wdata[0]. A write with host_sel=0 clears the status bits marked by 1s in wdata[3:0] and leaves the other bits alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cold_boot | input | 1 | Cold-start indication, sampled on the first edge after reset |
| main_fail_i | input | 1 | Main-supply failure flag from the comparator |
| bat_above_i | input | 1 | Battery-above-main flag |
| bat_low_i | input | 1 | Low-battery flag |
| time_i | input | TIME_W | Live time fields from the counters |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = status clear, 1 = control register |
| host_wdata | input | DEB_W+8 | Host write data |
| irq_o | output | 1 | Power-fail interrupt request |
| lockout_o | output | 1 | Host interface locked out |
| bat_sel_o | output | 1 | Supply select: 1 = battery |
| status_o | output | 4 | Sticky status: {low battery, system power, cold start, interrupt} |
| ts_en_o | output | 1 | Time-save enable readback |
| deb_len_o | output | DEB_W | Debounce length readback |
| saved_time_o | output | TIME_W | Time captured at the power failure |

## Verification
The hardest case to reach is a second rising edge of the battery flag within the same failure event, which must not overwrite the saved time. A closely related case is the re-arming of the capture after recovery. The stimulus holds a debounced failure and changes the time bus. It then bounces the battery flag low and high, and checks that the saved value is unchanged. After a full recovery, a new failure must capture fresh time. Glitches on the failure flag of random width, each shorter than a random debounce length, check that sub-threshold pulses never lock the host out.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int ST_W       = 4;
  localparam int ST_IRQ     = 0;
  localparam int ST_COLD    = 1;
  localparam int ST_SYSPWR  = 2;
  localparam int ST_LOWBAT  = 3;
endpackage

// File: rtl/pfc_debounce.sv
module pfc_debounce #(
  parameter int DEB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic [DEB_W-1:0] len,
  output logic             q,
  output logic             q_nxt,
  output logic             rise,
  output logic             fall
);
  logic [DEB_W-1:0] cnt;
  logic             differ;
  logic             hit;

  // A mismatch seen on this edge completes the window when count+1 reaches the length.
  function automatic logic deb_hit(input logic [DEB_W-1:0] c, input logic [DEB_W-1:0] l);
    logic [DEB_W:0] tgt;
    tgt = (l == '0) ? {{DEB_W{1'b0}}, 1'b1} : {1'b0, l};
    return ({1'b0, c} + 1'b1) >= tgt;
  endfunction

  assign differ = (raw != q);
  assign hit    = differ && deb_hit(cnt, len);
  assign q_nxt  = hit ? raw : q;
  assign rise   = hit & raw;
  assign fall   = hit & ~raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      cnt <= '0;
    end else begin
      q <= q_nxt;
      if (!differ || hit) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end

  // R2: the filtered state only moves toward the value the input held last edge
  a_r2_follow_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> (q == $past(raw)));
  // R2: a matching input never leaves a count pending
  a_r2_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == q) |=> (cnt == '0));
endmodule

// File: rtl/pfc_status.sv
module pfc_status
  import pfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cold_boot,
  input  logic            pf_rise,
  input  logic            pf_fall,
  input  logic            low_bat,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_mask,
  output logic [ST_W-1:0] stat
);
  logic            first_q;
  logic [ST_W-1:0] set_v;
  logic [ST_W-1:0] clr_v;

  always_comb begin
    set_v             = '0;
    set_v[ST_IRQ]     = pf_rise;
    set_v[ST_COLD]    = first_q & cold_boot;
    set_v[ST_SYSPWR]  = pf_fall;
    set_v[ST_LOWBAT]  = low_bat;
    clr_v             = clr_we ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat    <= '0;
      first_q <= 1'b1;
    end else begin
      first_q <= 1'b0;
      stat    <= (stat & ~clr_v) | set_v;
    end
  end

  // R4: the interrupt bit holds until an accepted clear
  a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[ST_IRQ] && !clr_v[ST_IRQ]) |=> stat[ST_IRQ]);
  // R10: low battery input is recorded on the next edge
  a_r10_lowbat_set: assert property (@(posedge clk) disable iff (!rst_n)
    low_bat |=> stat[ST_LOWBAT]);
  // R9: the cold-start bit can only appear on the first cycle after reset
  a_r9_cold_once: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat[ST_COLD] && !first_q) |=> !stat[ST_COLD]);
endmodule

// File: rtl/pfc_timesave.sv
module pfc_timesave #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bat_above,
  input  logic              pf_hold_nxt,
  input  logic              pf_fall,
  input  logic              ts_en,
  input  logic [TIME_W-1:0] time_i,
  output logic              bat_sel,
  output logic [TIME_W-1:0] saved,
  output logic              snap
);
  logic bat_d;
  logic armed;

  assign snap = bat_above & ~bat_d & ts_en & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bat_d   <= 1'b0;
      armed   <= 1'b1;
      bat_sel <= 1'b0;
      saved   <= '0;
    end else begin
      bat_d   <= bat_above;
      bat_sel <= bat_above | (bat_sel & pf_hold_nxt);
      if (snap) saved <= time_i;
      if (pf_fall)   armed <= 1'b1;
      else if (snap) armed <= 1'b0;
    end
  end

  // R6: battery above main moves the select on the next edge
  a_r6_batsel: assert property (@(posedge clk) disable iff (!rst_n)
    bat_above |=> bat_sel);
  // R7: one capture per event
  a_r7_snap_once: assert property (@(posedge clk) disable iff (!rst_n)
    (snap && !pf_fall) |=> !armed);
  // R8: the saved time only changes while time-save was enabled
  a_r8_need_en: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(saved) |-> $past(ts_en));
endmodule

// File: rtl/pwr_fail_ctrl.sv
module pwr_fail_ctrl
  import pfc_pkg::*;
#(
  parameter int TIME_W  = 32,
  parameter int DEB_W   = 8,
  parameter int DEB_RST = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cold_boot,
  input  logic                main_fail_i,
  input  logic                bat_above_i,
  input  logic                bat_low_i,
  input  logic [TIME_W-1:0]   time_i,
  input  logic                host_we,
  input  logic                host_sel,
  input  logic [DEB_W+7:0]    host_wdata,
  output logic                irq_o,
  output logic                lockout_o,
  output logic                bat_sel_o,
  output logic [ST_W-1:0]     status_o,
  output logic                ts_en_o,
  output logic [DEB_W-1:0]    deb_len_o,
  output logic [TIME_W-1:0]   saved_time_o
);
  localparam logic [DEB_W-1:0] DEB_INIT = DEB_W'(DEB_RST);

  logic pf_q, pf_nxt, pf_rise, pf_fall;
  logic host_ok, ctrl_wr, stat_clr;
  logic snap_evt;
  logic ts_en;
  logic [DEB_W-1:0] deb_len;

  assign host_ok  = host_we & ~pf_q;
  assign ctrl_wr  = host_ok & host_sel;
  assign stat_clr = host_ok & ~host_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_en   <= 1'b0;
      deb_len <= DEB_INIT;
    end else if (ctrl_wr) begin
      ts_en   <= host_wdata[0];
      deb_len <= host_wdata[DEB_W+7:8];
    end
  end

  pfc_debounce #(.DEB_W(DEB_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw(main_fail_i), .len(deb_len),
    .q(pf_q), .q_nxt(pf_nxt), .rise(pf_rise), .fall(pf_fall)
  );

  pfc_status u_stat (
    .clk(clk), .rst_n(rst_n), .cold_boot(cold_boot),
    .pf_rise(pf_rise), .pf_fall(pf_fall), .low_bat(bat_low_i),
    .clr_we(stat_clr), .clr_mask(host_wdata[ST_W-1:0]), .stat(status_o)
  );

  pfc_timesave #(.TIME_W(TIME_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .bat_above(bat_above_i),
    .pf_hold_nxt(pf_nxt), .pf_fall(pf_fall), .ts_en(ts_en),
    .time_i(time_i), .bat_sel(bat_sel_o), .saved(saved_time_o),
    .snap(snap_evt)
  );

  assign lockout_o = pf_q;
  assign irq_o     = status_o[ST_IRQ];
  assign ts_en_o   = ts_en;
  assign deb_len_o = deb_len;

  // R3: control state cannot move while locked
  a_r3_lock_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_o |=> $stable({ts_en, deb_len}));
  // R4: entering lockout always comes with the interrupt
  a_r4_irq_with_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout_o) |-> irq_o);
  // R5: leaving lockout always records system power
  a_r5_syspwr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockout_o) |-> status_o[ST_SYSPWR]);
endmodule

// File: tb/pwr_fail_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_fail_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cold_boot = 1'b1;
  logic        main_fail_i = 1'b0;
  logic        bat_above_i = 1'b0;
  logic        bat_low_i = 1'b0;
  logic [31:0] time_i = '0;
  logic        host_we = 1'b0;
  logic        host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        irq_o, lockout_o, bat_sel_o, ts_en_o;
  logic [3:0]  status_o;
  logic [7:0]  deb_len_o;
  logic [31:0] saved_time_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_fail_ctrl u_pwr_fail_ctrl (
    .clk(clk), .rst_n(rst_n), .cold_boot(cold_boot), .main_fail_i(main_fail_i),
    .bat_above_i(bat_above_i), .bat_low_i(bat_low_i), .time_i(time_i),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .irq_o(irq_o), .lockout_o(lockout_o), .bat_sel_o(bat_sel_o),
    .status_o(status_o), .ts_en_o(ts_en_o), .deb_len_o(deb_len_o),
    .saved_time_o(saved_time_o)
  );

  // effective debounce window from the requirement: zero counts as one
  function automatic int win(input int len);
    return (len == 0) ? 1 : len;
  endfunction

  function automatic logic [15:0] ctrl_word(input int len, input bit en);
    return {8'(len), 7'd0, en};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input bit sel, input logic [15:0] d);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    tick(1);
    host_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, n2;
    logic [31:0] t1, t2, t3, t4;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1 status", status_o, 4'h0);
    chk("R1 outputs", {irq_o, lockout_o, bat_sel_o, ts_en_o}, 4'b0000);
    chk("R1 deb_len", deb_len_o, 8'd4);
    tick(1);
    cold_boot = 1'b0;
    chk("R9 cold bit set", status_o[1], 1'b1);
    tick(2);
    chk("R9 cold bit holds", status_o[1], 1'b1);
    hwrite(1'b0, 16'h0002);
    chk("R9 R11 cold bit cleared", status_o, 4'h0);

    n = 2 + int'($urandom % 5);
    hwrite(1'b1, ctrl_word(n, 1'b1));
    chk("R11 ctrl len", deb_len_o, 8'(n));
    chk("R11 ctrl en", ts_en_o, 1'b1);

    // R2 random glitches shorter than the window
    for (int i = 0; i < 6; i++) begin
      int w;
      w = 1 + int'($urandom % (win(n) - 1));
      main_fail_i = 1'b1; tick(w);
      main_fail_i = 1'b0; tick(3);
      chk("R2 glitch ignored", {lockout_o, irq_o}, 2'b00);
    end

    // real failure
    main_fail_i = 1'b1;
    tick(win(n) - 1);
    chk("R2 not yet locked", lockout_o, 1'b0);
    tick(1);
    chk("R3 locked", lockout_o, 1'b1);
    chk("R4 irq set", {irq_o, status_o[0]}, 2'b11);

    // R7 capture and bounce
    t1 = $urandom; time_i = t1; bat_above_i = 1'b1;
    tick(1);
    chk("R6 bat select", bat_sel_o, 1'b1);
    chk("R7 captured", saved_time_o, t1);
    t2 = ~t1; time_i = t2; bat_above_i = 1'b0;
    tick(1);
    chk("R6 select held in failure", bat_sel_o, 1'b1);
    bat_above_i = 1'b1;
    tick(1);
    chk("R7 once per event", saved_time_o, t1);

    bat_low_i = 1'b1; tick(1); bat_low_i = 1'b0; tick(1);
    chk("R10 low battery sticky", status_o[3], 1'b1);

    // R3 writes blocked
    hwrite(1'b0, 16'h000F);
    chk("R3 clear blocked", {status_o[3], status_o[0]}, 2'b11);
    hwrite(1'b1, ctrl_word(9, 1'b0));
    chk("R3 ctrl blocked", {deb_len_o, ts_en_o}, {8'(n), 1'b1});

    // R5 recovery
    main_fail_i = 1'b0; bat_above_i = 1'b0;
    tick(win(n) - 1);
    chk("R5 still locked", {lockout_o, bat_sel_o}, 2'b11);
    tick(1);
    chk("R5 released", lockout_o, 1'b0);
    chk("R6 back to main", bat_sel_o, 1'b0);
    chk("R5 syspwr", status_o[2], 1'b1);
    chk("R4 irq persists", irq_o, 1'b1);
    hwrite(1'b0, 16'h0001);
    chk("R4 irq cleared", irq_o, 1'b0);
    chk("R11 mask only bit0", status_o, 4'b1100);
    hwrite(1'b0, 16'h000C);
    chk("R10 R11 cleared", status_o, 4'h0);

    // R8 disabled capture
    n2 = 2 + int'($urandom % 5);
    hwrite(1'b1, ctrl_word(n2, 1'b0));
    chk("R11 new len", {deb_len_o, ts_en_o}, {8'(n2), 1'b0});
    main_fail_i = 1'b1; tick(win(n2));
    chk("R3 locked again", lockout_o, 1'b1);
    t3 = $urandom; time_i = t3; bat_above_i = 1'b1; tick(1);
    chk("R8 no capture", saved_time_o, t1);
    bat_above_i = 1'b0; main_fail_i = 1'b0; tick(win(n2));
    chk("R5 released again", lockout_o, 1'b0);

    // R7 re-armed
    hwrite(1'b1, ctrl_word(n2, 1'b1));
    main_fail_i = 1'b1; tick(win(n2));
    t4 = $urandom ^ 32'h5a5a_0001; time_i = t4; bat_above_i = 1'b1; tick(1);
    chk("R7 re-armed capture", saved_time_o, t4);
    bat_above_i = 1'b0; main_fail_i = 1'b0; tick(win(n2));
    hwrite(1'b0, 16'h000F);

    // R6 without failure
    bat_above_i = 1'b1; tick(1);
    chk("R6 select on flag", bat_sel_o, 1'b1);
    bat_above_i = 1'b0; tick(1);
    chk("R6 select released", bat_sel_o, 1'b0);

    // R2 zero length acts as one
    hwrite(1'b1, ctrl_word(0, 1'b1));
    main_fail_i = 1'b1; tick(1);
    chk("R2 zero length", lockout_o, 1'b1);
    main_fail_i = 1'b0; tick(1);
    chk("R2 zero length release", lockout_o, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule